// File: doc/BRIEF.md
# RS-485 Transmit Ring with Driver-Enable Sequencing

The block queues outgoing bytes in a circular buffer and sends them as 8N1 UART frames (one low start bit, eight data bits least significant first, one high stop bit). It also drives the enable pin of an RS-485 line driver. A request handler writes response bytes through a one-byte write port and then pulses `start`. The block raises `drv_en` and moves bytes one at a time from the ring into an internal shift register. When the ring runs dry it returns both ring pointers to zero. It holds the driver on until the last stop bit has completely left the shifter, so the final byte is never cut short on the bus.

The bit period is `CLK_HZ / BAUD` clock cycles, rounded to the nearest integer (9600 baud by default). `busy` mirrors the driver-enable window, so a receive path can drop requests that arrive while a reply is still on the wire.

Control states: `CTL_IDLE` (driver off), `CTL_FEED` (moving bytes into the shifter), `CTL_DRAIN` (ring empty, waiting for the shifter to go quiet). The transitions are: IDLE→FEED on `start`; FEED→DRAIN when the ring is empty, which also clears the pointers; DRAIN→IDLE when the shifter is idle. Shifter states: `SH_IDLE`→`SH_START` on load, `SH_START`→`SH_DATA` after one bit period, `SH_DATA`→`SH_STOP` after eight bit periods, and `SH_STOP`→`SH_IDLE` after one bit period.

Top module: `rs485_tx_ring`

## Requirements
- R1: After reset `tx` is 1 and `drv_en` and `busy` are 0.
- R2: Each byte is sent as one 0 start bit, then eight data bits with bit 0 first, then one 1 stop bit. Each bit lasts CPB = round(CLK_HZ/BAUD) clocks. `tx` is 1 whenever `drv_en` is 0.
- R3: Bytes leave in the order in which they were accepted, and only accepted bytes are sent.
- R4: The ring holds at most DEPTH-1 bytes. A write is accepted only when head+1 (mod DEPTH) differs from tail. A write to a full ring is discarded and leaves the ring unchanged.
- R5: `drv_en` is 1 in the cycle after the clock edge that samples `start` while the block is idle.
- R6: `drv_en` stays 1 through the whole stop bit of the last byte. It falls exactly CPB/2+1 clocks after the middle of that stop bit, which is one clock after the stop bit ends.
- R7: `busy` equals `drv_en` at all times.
- R8: When the ring drains, head and tail return to zero. A fresh session then accepts exactly DEPTH-1 bytes.
- R9: A `start` on an empty ring raises `drv_en` for two clocks and sends no frame.
- R10: A `start` while `drv_en` is 1 is ignored. Bytes written during a session before the ring drains are sent in that same session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | DW | Byte to enqueue |
| start | input | 1 | Begin sending the queued bytes |
| tx | output | 1 | Serial UART output, idle high |
| drv_en | output | 1 | RS-485 line driver enable |
| busy | output | 1 | High while a response is being sent |

## Verification
The assertions assume that `start` and `wr_en` are driven synchronously and are never X after reset. They also assume the overflow rule only needs checking when a write and a pop do not fall in the same cycle. The bench drives all inputs on falling clock edges, so they are settled at every rising edge. It fills the ring beyond capacity only while the driver is off. The scoreboard's model of how many bytes the ring holds then matches the hardware exactly: occupancy starts from zero after every drain and is not consumed by pops in the meantime.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_FEED,
        CTL_DRAIN
    } ctl_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_t;
endpackage

// File: rtl/rs485_ring.sv
module rs485_ring #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pop,
    input  logic                     clear,
    output logic [DW-1:0]            rd_data,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH)-1:0] head,
    output logic [$clog2(DEPTH)-1:0] tail
);
    localparam int AW = $clog2(DEPTH);

    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_depth_check
        $error("ring depth must be a power of two");
    end

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head_q, tail_q;
    logic [AW-1:0] head_inc;
    logic          accept;

    // AW-bit arithmetic wraps modulo DEPTH on its own.
    assign head_inc = head_q + AW'(1);
    assign full     = (head_inc == tail_q);
    assign empty    = (head_q == tail_q);
    assign accept   = wr_en && (clear || !full);
    assign rd_data  = mem[tail_q];
    assign head     = head_q;
    assign tail     = tail_q;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[clear ? '0 : head_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear) begin
            // a write in the same cycle lands in slot 0
            head_q <= accept ? AW'(1) : '0;
            tail_q <= '0;
        end else begin
            if (accept) head_q <= head_inc;
            if (pop)    tail_q <= tail_q + AW'(1);
        end
    end
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
    import rs485_tx_pkg::*;
#(
    parameter int CPB = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          ready,
    output logic          tx
);
    localparam int CW = (CPB > 2) ? $clog2(CPB) : 1;
    localparam int BW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CPB - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    sh_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [BW-1:0] bit_q, bit_d;
    logic [DW-1:0] sh_q, sh_d;
    logic          tick;

    assign tick = (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = tick ? '0 : cnt_q + CW'(1);
        bit_d   = bit_q;
        sh_d    = sh_q;
        unique case (state_q)
            SH_IDLE: begin
                cnt_d = '0;
                if (load) begin
                    sh_d    = data;
                    bit_d   = '0;
                    state_d = SH_START;
                end
            end
            SH_START: begin
                if (tick) state_d = SH_DATA;
            end
            SH_DATA: begin
                if (tick) begin
                    sh_d = sh_q >> 1;
                    if (bit_q == BIT_LAST) state_d = SH_STOP;
                    else                   bit_d   = bit_q + BW'(1);
                end
            end
            SH_STOP: begin
                if (tick) state_d = SH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        ready = 1'b0;
        tx    = 1'b1;
        unique case (state_q)
            SH_IDLE:  ready = 1'b1;
            SH_START: tx    = 1'b0;
            SH_DATA:  tx    = sh_q[0];
            SH_STOP:  tx    = 1'b1;
        endcase
    end
endmodule

// File: rtl/rs485_de_ctrl.sv
module rs485_de_ctrl
    import rs485_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ring_empty,
    input  logic sh_ready,
    output logic pop_load,
    output logic clear,
    output logic drv_en,
    output logic busy
);
    ctl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:  if (start)      state_d = CTL_FEED;
            CTL_FEED:  if (ring_empty) state_d = CTL_DRAIN;
            CTL_DRAIN: if (sh_ready)   state_d = CTL_IDLE;
            default:                   state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pop_load = 1'b0;
        clear    = 1'b0;
        drv_en   = 1'b1;
        unique case (state_q)
            CTL_IDLE:  drv_en   = 1'b0;
            CTL_FEED: begin
                pop_load = !ring_empty && sh_ready;
                clear    = ring_empty;
            end
            CTL_DRAIN: ;
            default:   drv_en   = 1'b0;
        endcase
        busy = drv_en;
    end
endmodule

// File: rtl/rs485_tx_ring.sv
module rs485_tx_ring #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600,
    parameter int DEPTH  = 128,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          start,
    output logic          tx,
    output logic          drv_en,
    output logic          busy
);
    localparam int CPB = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int AW  = $clog2(DEPTH);

    logic [DW-1:0] rd_data;
    logic          ring_empty, ring_full;
    logic [AW-1:0] head_ptr, tail_ptr;
    logic          pop_load, clear, sh_ready;

    rs485_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop_load),
        .clear   (clear),
        .rd_data (rd_data),
        .empty   (ring_empty),
        .full    (ring_full),
        .head    (head_ptr),
        .tail    (tail_ptr)
    );

    rs485_uart_tx #(.CPB(CPB), .DW(DW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pop_load),
        .data  (rd_data),
        .ready (sh_ready),
        .tx    (tx)
    );

    rs485_de_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ring_empty (ring_empty),
        .sh_ready   (sh_ready),
        .pop_load   (pop_load),
        .clear      (clear),
        .drv_en     (drv_en),
        .busy       (busy)
    );
endmodule

// File: rtl/rs485_tx_chk.sv
module rs485_tx_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          wr_en,
    input logic          tx,
    input logic          drv_en,
    input logic          ring_full,
    input logic          pop_load,
    input logic          sh_ready,
    input logic [AW-1:0] head_ptr,
    input logic [AW-1:0] tail_ptr
);
    // R4: a full ring ignores writes
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full && wr_en && !pop_load |=> head_ptr == $past(head_ptr));

    // R5: start from idle turns the driver on next cycle
    p_de_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start && !drv_en |=> drv_en);

    // R6: driver stays on while the shifter is active
    p_de_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_ready |-> drv_en);

    // R2: line idles high while the driver is off
    p_line_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> tx);

    // R8: ring is back at slot zero once the driver drops
    p_ptr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> tail_ptr == '0);
endmodule

bind rs485_tx_ring rs485_tx_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .tx        (tx),
    .drv_en    (drv_en),
    .ring_full (ring_full),
    .pop_load  (pop_load),
    .sh_ready  (sh_ready),
    .head_ptr  (head_ptr),
    .tail_ptr  (tail_ptr)
);

// File: tb/tb_rs485_tx_ring.sv
module tb_rs485_tx_ring;
    localparam int BAUD  = 9600;
    localparam int CPB   = 16;
    localparam int DEPTH = 128;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          start = 1'b0;
    logic          tx, drv_en, busy;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int occ    = 0;
    logic [DW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    rs485_tx_ring #(.CLK_HZ(CPB * BAUD), .BAUD(BAUD), .DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .start(start), .tx(tx), .drv_en(drv_en), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: enqueue into the model when the ring would accept (R4)
    task automatic write_byte(input logic [DW-1:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (occ < DEPTH - 1) begin
            exp_q.push_back(b);
            occ++;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (drv_en) @(negedge clk);
        check(busy == drv_en, "R7", busy, drv_en);
        occ = 0;
    endtask

    // monitor: decode frames and compare with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx == 1'b0) begin
                logic [DW-1:0] got;
                bit ok;
                int n;
                ok = 1'b1;
                repeat (CPB / 2) @(negedge clk);
                if (tx != 1'b0) ok = 1'b0;
                for (int i = 0; i < DW; i++) begin
                    repeat (CPB) @(negedge clk);
                    got[i] = tx;
                end
                repeat (CPB) @(negedge clk);
                check(ok && tx == 1'b1, "R2", {ok, tx}, 3);
                check(drv_en == 1'b1, "R6", drv_en, 1);
                frames++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", got, -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R3", got, e);
                end
                if (exp_q.size() == 0) begin
                    n = 0;
                    while (drv_en && n < 4 * CPB) begin
                        @(negedge clk);
                        n++;
                        if (tx != 1'b1) ok = 1'b0;
                    end
                    check(ok && n == CPB / 2 + 1, "R6", n, CPB / 2 + 1);
                end
            end
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        bit quiet;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx == 1'b1 && drv_en == 1'b0 && busy == 1'b0, "R1",
              {tx, drv_en, busy}, 3'b100);

        // R9: start with an empty ring
        f0 = frames;
        pulse_start();
        check(drv_en == 1'b1, "R9", drv_en, 1);
        quiet = (tx == 1'b1);
        @(negedge clk);
        check(drv_en == 1'b1, "R9", drv_en, 1);
        @(negedge clk);
        quiet = quiet && (tx == 1'b1);
        check(drv_en == 1'b0 && quiet, "R9", drv_en, 0);
        repeat (20) @(negedge clk);
        check(frames == f0, "R9", frames, f0);

        // R2 R3: distinct patterns
        write_byte(8'hA5);
        write_byte(8'h3C);
        write_byte(8'h00);
        write_byte(8'hFF);
        write_byte(8'h81);
        pulse_start();
        check(drv_en == 1'b1 && busy == 1'b1, "R5", drv_en, 1);
        wait_idle();
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);

        // R10: bytes added mid-session, extra start ignored
        f0 = frames;
        write_byte(8'h11);
        write_byte(8'h22);
        pulse_start();
        write_byte(8'h33);
        write_byte(8'h44);
        pulse_start();
        wait_idle();
        check(frames - f0 == 4, "R10", frames - f0, 4);
        repeat (40) @(negedge clk);
        check(frames - f0 == 4 && drv_en == 1'b0, "R10", frames - f0, 4);

        // R4: overfill
        f0 = frames;
        for (int i = 0; i < DEPTH + 2; i++) write_byte(DW'(i * 7 + 1));
        pulse_start();
        wait_idle();
        check(frames - f0 == DEPTH - 1, "R4", frames - f0, DEPTH - 1);

        // R8: after drain the ring takes a full load again
        f0 = frames;
        for (int i = 0; i < DEPTH + 1; i++) write_byte(DW'(255 - i));
        pulse_start();
        wait_idle();
        check(frames - f0 == DEPTH - 1, "R8", frames - f0, DEPTH - 1);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule